// File: doc/BRIEF.md
# Exception Return Status Unstacker

This block carries out the status-word half of a return from an ordinary exception or from a non-maskable interrupt. When the processor asks for a return, it passes in the current 32-bit status word, the live stack pointer and the saved user stack pointer. The block pops the saved status field down to its live position, applies the flag corrections that the chosen return type calls for, and swaps stack pointers when the popped status puts the processor in user mode.

A one-cycle strobe starts the operation, and a type select is sampled with it. All three results are registered and appear on the clock edge that captures the strobe. Between strobes they hold, so the surrounding pipeline can read them whenever it needs to. Fetching the return address and performing the branch are handled elsewhere.

Top module: `exc_return_unstacker`

## Requirements
- R1: While reset is high, and after it is released with no strobe, `status_q`, `sp_q` and `ksp_q` are all zero.
- R2: On a strobe, bits [31:30] of the new status equal bits [31:30] of `status_in`. The one exception is bit 30 on an NMI return (see R8).
- R3: On a strobe, bits [29:28] of the new status are zero.
- R4: On a strobe, bits [27:0] of the new status equal `status_in[27:0]` shifted right by 10 with zero fill. The one exception is the pending flag at bit 7 (see R7).
- R5: If bit 8 (user mode) of the new status is set, `sp_q` takes `usp_in` and `ksp_q` takes `sp_in`.
- R6: If bit 8 of the new status is clear, `sp_q` takes `sp_in` and `ksp_q` keeps its previous value.
- R7: If `status_in` bit 6 is clear, bit 7 of the new status is forced to 1. If bit 6 is set, bit 7 keeps the shifted value (old bit 17).
- R8: With `ret_nmi`=1 (NMI return), bit 30 of the new status is forced to 1.
- R9: With `ret_nmi`=0 (exception return), bit 30 of the new status equals old bit 30.
- R10: Outputs change only on the clock edge that samples `ret_go`=1. With `ret_go`=0, input changes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_go | input | 1 | One-cycle request to perform a return |
| ret_nmi | input | 1 | Return type: 0 exception return, 1 NMI return |
| status_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| status_q | output | 32 | Unstacked and corrected status word |
| sp_q | output | 32 | Stack pointer after the return |
| ksp_q | output | 32 | Saved kernel stack pointer |

## Verification
Two functions can act on the same strobe: the stack-pointer swap, which depends on old bit 18 after it lands at bit 8, and the pending-flag correction, which depends on old bit 6. A strobe with both of those bits arranged triggers both at once. An NMI return on the same kind of word also forces bit 30, so three corrections land in one capture. The bench builds such words and compares all three outputs against an independent model on the next falling edge. It also checks that the pending-flag decision uses the pre-shift bit 6 and not the bit that shifts into that position.

// File: rtl/eru_pkg.sv
package eru_pkg;
    localparam int WORD_W     = 32;
    localparam int DEF_SHIFT  = 10;
    localparam int DEF_FIELD  = 28;
    localparam int DEF_KEEP   = 2;
    localparam int DEF_U_BIT  = 8;
    localparam int DEF_P_BIT  = 7;
    localparam int DEF_R_BIT  = 6;
    localparam int DEF_M_BIT  = 30;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        RET_EXC = 1'b0,
        RET_NMI = 1'b1
    } ret_kind_e;

    typedef struct packed {
        word_t status;
        word_t sp;
        word_t ksp;
    } ret_state_t;

    function automatic word_t set_bit(input word_t w, input int pos, input logic en);
        word_t r;
        r = w;
        if (en) r[pos] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/eru_unstack.sv
module eru_unstack
    import eru_pkg::*;
#(
    parameter int SHIFT   = DEF_SHIFT,
    parameter int FIELD_W = DEF_FIELD,
    parameter int KEEP_W  = DEF_KEEP
) (
    input  word_t old_status,
    output word_t popped
);
    localparam int GAP_W = WORD_W - KEEP_W - FIELD_W;

    logic [FIELD_W-1:0] field_old;
    logic [FIELD_W-1:0] field_new;

    assign field_old = old_status[FIELD_W-1:0];
    assign field_new = field_old >> SHIFT;

    generate
        if (GAP_W > 0) begin : g_gap
            assign popped = {old_status[WORD_W-1 -: KEEP_W], {GAP_W{1'b0}}, field_new};
        end else begin : g_nogap
            assign popped = {old_status[WORD_W-1 -: KEEP_W], field_new};
        end
    endgenerate
endmodule

// File: rtl/eru_fixup.sv
module eru_fixup
    import eru_pkg::*;
#(
    parameter int P_BIT = DEF_P_BIT,
    parameter int R_BIT = DEF_R_BIT,
    parameter int M_BIT = DEF_M_BIT
) (
    input  word_t     old_status,
    input  word_t     popped,
    input  ret_kind_e kind,
    output word_t     fixed
);
    logic need_pend;
    logic need_m;
    word_t stage1;

    assign need_pend = ~old_status[R_BIT];
    assign need_m    = (kind == RET_NMI);

    always_comb begin
        stage1 = set_bit(popped, P_BIT, need_pend);
        fixed  = set_bit(stage1, M_BIT, need_m);
    end
endmodule

// File: rtl/eru_stack.sv
module eru_stack
    import eru_pkg::*;
#(
    parameter int U_BIT = DEF_U_BIT
) (
    input  word_t new_status,
    input  word_t sp_cur,
    input  word_t usp_saved,
    input  word_t ksp_cur,
    output word_t sp_next,
    output word_t ksp_next
);
    logic to_user;
    assign to_user = new_status[U_BIT];

    always_comb begin
        if (to_user) begin
            sp_next  = usp_saved;
            ksp_next = sp_cur;
        end else begin
            sp_next  = sp_cur;
            ksp_next = ksp_cur;
        end
    end
endmodule

// File: rtl/exc_return_unstacker.sv
module exc_return_unstacker
    import eru_pkg::*;
#(
    parameter int SHIFT   = DEF_SHIFT,
    parameter int FIELD_W = DEF_FIELD,
    parameter int KEEP_W  = DEF_KEEP,
    parameter int U_BIT   = DEF_U_BIT,
    parameter int P_BIT   = DEF_P_BIT,
    parameter int R_BIT   = DEF_R_BIT,
    parameter int M_BIT   = DEF_M_BIT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ret_go,
    input  logic        ret_nmi,
    input  logic [31:0] status_in,
    input  logic [31:0] sp_in,
    input  logic [31:0] usp_in,
    output logic [31:0] status_q,
    output logic [31:0] sp_q,
    output logic [31:0] ksp_q
);
    ret_kind_e  kind;
    word_t      popped;
    word_t      fixed;
    ret_state_t cur;
    ret_state_t nxt;

    assign kind = ret_kind_e'(ret_nmi);

    eru_unstack #(.SHIFT(SHIFT), .FIELD_W(FIELD_W), .KEEP_W(KEEP_W)) u_unstack (
        .old_status (status_in),
        .popped     (popped)
    );

    eru_fixup #(.P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)) u_fixup (
        .old_status (status_in),
        .popped     (popped),
        .kind       (kind),
        .fixed      (fixed)
    );

    eru_stack #(.U_BIT(U_BIT)) u_stack (
        .new_status (fixed),
        .sp_cur     (sp_in),
        .usp_saved  (usp_in),
        .ksp_cur    (cur.ksp),
        .sp_next    (nxt.sp),
        .ksp_next   (nxt.ksp)
    );

    assign nxt.status = fixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (ret_go) begin
            cur <= nxt;
        end
    end

    assign status_q = cur.status;
    assign sp_q     = cur.sp;
    assign ksp_q    = cur.ksp;
endmodule

// File: rtl/eru_checker.sv
module eru_checker #(
    parameter int SHIFT   = 10,
    parameter int FIELD_W = 28,
    parameter int U_BIT   = 8,
    parameter int P_BIT   = 7,
    parameter int R_BIT   = 6,
    parameter int M_BIT   = 30
) (
    input logic        clk,
    input logic        rst,
    input logic        ret_go,
    input logic        ret_nmi,
    input logic [31:0] status_in,
    input logic [31:0] sp_in,
    input logic [31:0] usp_in,
    input logic [31:0] status_q,
    input logic [31:0] sp_q,
    input logic [31:0] ksp_q
);
    logic [FIELD_W-1:0] exp_field;
    logic [FIELD_W-1:0] pmask;
    assign exp_field = status_in[FIELD_W-1:0] >> SHIFT;
    assign pmask     = ~(FIELD_W'(1) << P_BIT);

    p_top_keep_r2: assert property (@(posedge clk) disable iff (rst)
        ret_go |=> status_q[31] == $past(status_in[31]));

    p_gap_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ret_go |=> status_q[29:28] == 2'b00);

    p_field_shift_r4: assert property (@(posedge clk) disable iff (rst)
        ret_go |=> (status_q[FIELD_W-1:0] & pmask) == ($past(exp_field) & pmask));

    p_user_swap_r5: assert property (@(posedge clk) disable iff (rst)
        (ret_go && status_in[U_BIT+SHIFT]) |=> (sp_q == $past(usp_in)) && (ksp_q == $past(sp_in)));

    p_kernel_stay_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_go && !status_in[U_BIT+SHIFT]) |=> (sp_q == $past(sp_in)) && $stable(ksp_q));

    p_pend_set_r7: assert property (@(posedge clk) disable iff (rst)
        (ret_go && !status_in[R_BIT]) |=> status_q[P_BIT]);

    p_nmi_m_r8: assert property (@(posedge clk) disable iff (rst)
        (ret_go && ret_nmi) |=> status_q[M_BIT]);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !ret_go |=> $stable(status_q) && $stable(sp_q) && $stable(ksp_q));
endmodule

bind exc_return_unstacker eru_checker #(
    .SHIFT(SHIFT), .FIELD_W(FIELD_W), .U_BIT(U_BIT),
    .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
) u_chk (
    .clk(clk), .rst(rst), .ret_go(ret_go), .ret_nmi(ret_nmi),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in),
    .status_q(status_q), .sp_q(sp_q), .ksp_q(ksp_q)
);

// File: tb/sim_exc_return_unstacker.sv
module sim_exc_return_unstacker;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        ret_go;
    logic        ret_nmi;
    logic [31:0] status_in;
    logic [31:0] sp_in;
    logic [31:0] usp_in;
    logic [31:0] status_q;
    logic [31:0] sp_q;
    logic [31:0] ksp_q;

    int checks   = 0;
    int failures = 0;
    logic [31:0] ksp_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_return_unstacker u0 (
        .clk(clk), .rst(rst), .ret_go(ret_go), .ret_nmi(ret_nmi),
        .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in),
        .status_q(status_q), .sp_q(sp_q), .ksp_q(ksp_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Model built from R2..R9
    function automatic logic [31:0] model_status(input logic [31:0] s, input logic nmi);
        logic [31:0] r;
        r = {s[31:30], 2'b00, 28'(s[27:0] >> 10)};
        if (!s[6]) r[7] = 1'b1;
        if (nmi) r[30] = 1'b1;
        return r;
    endfunction

    // Drive at negedge, capture at posedge, check at following negedge
    task automatic do_return(input string req, input logic [31:0] s, input logic nmi,
                             input logic [31:0] sp, input logic [31:0] usp);
        logic [31:0] es;
        logic [31:0] esp;
        es = model_status(s, nmi);
        if (es[8]) begin
            esp = usp;
            ksp_model = sp;
        end else begin
            esp = sp;
        end
        ret_go = 1'b1; ret_nmi = nmi; status_in = s; sp_in = sp; usp_in = usp;
        @(negedge clk);
        ret_go = 1'b0;
        check({req, " status"}, status_q, es);
        check({req, " sp"}, sp_q, esp);
        check({req, " ksp"}, ksp_q, ksp_model);
    endtask

    task automatic t_reset;
        check("R1 status", status_q, 32'h0);
        check("R1 sp", sp_q, 32'h0);
        check("R1 ksp", ksp_q, 32'h0);
    endtask

    task automatic t_exc_plain;
        // R2 R3 R4 R7: top kept, 29:28 cleared, pending set since bit6 clear
        do_return("R3", 32'hF000_0000, 1'b0, 32'h1000, 32'h2000);
        check("R2 hand", status_q, 32'hC000_0080);
        check("R9 bit30", {31'b0, status_q[30]}, 32'h1);
    endtask

    task automatic t_user_switch_r5;
        // bit18 -> U; bit6 set so no pending force
        do_return("R5", 32'h0004_0040, 1'b0, 32'hAAAA_0000, 32'h5555_0000);
        check("R5 hand status", status_q, 32'h0000_0100);
        check("R5 hand sp", sp_q, 32'h5555_0000);
        check("R5 hand ksp", ksp_q, 32'hAAAA_0000);
    endtask

    task automatic t_kernel_stay_r6;
        do_return("R6", 32'h0000_0040, 1'b0, 32'h1234_5678, 32'hFFFF_0000);
        check("R6 ksp held", ksp_q, 32'hAAAA_0000);
    endtask

    task automatic t_pend_from_shift_r7;
        // bit6 set: bit7 comes from old bit17
        do_return("R7", 32'h0002_0040, 1'b0, 32'h10, 32'h20);
        check("R7 hand", status_q, 32'h0000_0080);
        do_return("R7 clear", 32'h0000_0040, 1'b0, 32'h10, 32'h20);
        check("R7 hand clear", status_q, 32'h0);
    endtask

    task automatic t_nmi_r8;
        do_return("R8", 32'h0000_0040, 1'b1, 32'h30, 32'h40);
        check("R8 hand", status_q, 32'h4000_0000);
        // all corrections in one capture: user swap, pending, M
        do_return("R8 combined", 32'h8FC4_0000, 1'b1, 32'hBEEF_0000, 32'hCAFE_0000);
        check("R8 combined hand", status_q, 32'hC003_F180);
    endtask

    task automatic t_exc_keeps_bit30_r9;
        do_return("R9", 32'h4000_0000, 1'b0, 32'h50, 32'h60);
        check("R9 hand", status_q, 32'h4000_0080);
    endtask

    task automatic t_hold_r10;
        logic [31:0] s0, p0, k0;
        s0 = status_q; p0 = sp_q; k0 = ksp_q;
        ret_go = 1'b0; ret_nmi = 1'b1;
        status_in = 32'hFFFF_FFFF; sp_in = 32'h9999_9999; usp_in = 32'h7777_7777;
        repeat (3) @(negedge clk);
        check("R10 status", status_q, s0);
        check("R10 sp", sp_q, p0);
        check("R10 ksp", ksp_q, k0);
    endtask

    initial begin
        rst = 1'b1; ret_go = 1'b0; ret_nmi = 1'b0;
        status_in = '0; sp_in = '0; usp_in = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exc_plain();
        t_user_switch_r5();
        t_kernel_stay_r6();
        t_pend_from_shift_r7();
        t_nmi_r8();
        t_exc_keeps_bit30_r9();
        t_hold_r10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule